// File: doc/BRIEF.md
# Full-Duplex Framed Serial Port

This block is a synchronous serial port with independent transmit and receive halves. Each half has its own external bit clock and frame-sync line. A core-side write loads a 16-bit transmit holding register. At the start of each frame that value is moved into a shift register and sent most-significant bit first. On the receive side, a shift register collects bits and moves each completed word into a receive holding register, which the core reads.

All external serial lines pass through a synchronizer into the core clock domain, and the port works on the edges it detects there. A control register selects one of two word lengths, 8 bits or 16 bits. It also sets the direction of the transmit frame sync: the sync is either taken from the pin or generated by the port. Each direction signals the core with a single-cycle interrupt pulse. The receive pulse means a word is ready. The transmit pulse means the holding register may be refilled.

Top module: `serial_port_duplex`

## Requirements
- R1: After reset, rx_data_o is 0, both interrupt outputs are low, tx_dat_o is 0, tx_fs_o is 0 and tx_fs_oe_o is 0. This is 16-bit word mode with the frame sync taken from tx_fs_i.
- R2: In word mode, a frame sync sampled high on a falling edge of rx_sclk_i starts a frame. Sixteen data bits are then sampled, MSB first, on the next 16 falling edges. After that, rx_data_o holds the word and rx_int_o pulses high for exactly one core cycle. rx_data_o changes only together with that pulse.
- R3: With control bit 0 set (byte mode), the receive side collects 8 bits MSB first. rx_data_o then holds them in bits 7:0, with bits 15:8 at zero.
- R4: In word mode, the transmitted word appears on tx_dat_o MSB first. There is one bit per tx_sclk_i period, and each bit changes only after a rising edge. The first bit follows the rising edge after the falling edge that sampled the frame sync. tx_dat_o is 0 while no frame is in progress.
- R5: In byte mode, only bits 7:0 of the transmit register are sent, MSB first, over 8 clocks.
- R6: tx_int_o pulses for one core cycle each time the transmit register is copied into the shift register at a frame start.
- R7: If the transmit register is not written before the next frame sync, the previous word is sent again.
- R8: With control bit 1 set, tx_fs_oe_o is high and the port drives the frame sync. A write of new data makes tx_fs_o high for exactly one tx_sclk_i period, starting after a rising edge, and the data follows from the next period. Without a new write, no further frame pulse and no tx_int_o occur.
- R9: Transmit and receive frames can run at the same time without affecting each other.
- R10: Register writes use reg_we_i. reg_sel_i=0 selects the transmit data register, and reg_sel_i=1 selects the control register (bit 0 byte mode, bit 1 frame sync generated).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0: transmit data, 1: control |
| reg_wdata_i | input | 16 | Register write data |
| rx_data_o | output | 16 | Receive holding register |
| rx_int_o | output | 1 | Receive interrupt pulse |
| tx_int_o | output | 1 | Transmit interrupt pulse |
| tx_sclk_i | input | 1 | Transmit bit clock |
| tx_fs_i | input | 1 | Transmit frame sync input |
| tx_fs_o | output | 1 | Generated transmit frame sync |
| tx_fs_oe_o | output | 1 | Enable for the transmit frame sync output |
| tx_dat_o | output | 1 | Serial transmit data |
| rx_sclk_i | input | 1 | Receive bit clock |
| rx_fs_i | input | 1 | Receive frame sync |
| rx_dat_i | input | 1 | Serial receive data |

## Verification
The bench builds the port with its defaults: a 16-bit word, an 8-bit byte and a two-stage synchronizer. Both serial clocks run at sixteen core cycles per period, so edge-detection latency stays well inside each half period. This setting covers both word lengths, the two frame-sync directions, back-to-back reuse of the transmit register and a receive frame running fully alongside a transmit frame.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
  typedef struct packed {
    logic fs_gen;
    logic byte_mode;
  } sp_cfg_t;

  localparam int unsigned CFG_BYTE_BIT = 0;
  localparam int unsigned CFG_FSGEN_BIT = 1;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sp_rx.sv
module sp_rx #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              fs_i,
  input  logic              dat_i,
  input  logic              byte_mode_i,
  output logic [DATA_W-1:0] data_o,
  output logic              int_o
);
  localparam int unsigned CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST_W = CW'(DATA_W - 1);
  localparam logic [CW-1:0] LAST_B = CW'(BYTE_W - 1);

  logic              sclk_q, fall;
  logic              busy_q, byte_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              at_last;

  assign fall    = sclk_q & ~sclk_i;
  assign at_last = cnt_q == (byte_q ? LAST_B : LAST_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
      byte_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      data_o <= '0;
      int_o  <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      int_o  <= 1'b0;
      if (fall) begin
        if (busy_q) begin
          sh_q <= {sh_q[DATA_W-2:0], dat_i};
          if (at_last) begin
            data_o <= byte_q ? DATA_W'({sh_q[BYTE_W-2:0], dat_i})
                             : {sh_q[DATA_W-2:0], dat_i};
            int_o  <= 1'b1;
            busy_q <= fs_i;  // back-to-back frame
            byte_q <= byte_mode_i;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (fs_i) begin
          busy_q <= 1'b1;
          byte_q <= byte_mode_i;
          cnt_q  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/sp_tx.sv
module sp_tx #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              fs_i,
  input  logic              fs_gen_i,
  input  logic              byte_mode_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              dat_o,
  output logic              fs_o,
  output logic              int_o,
  output logic              rise_o
);
  localparam int unsigned CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST_W = CW'(DATA_W - 1);
  localparam logic [CW-1:0] LAST_B = CW'(BYTE_W - 1);

  logic              sclk_q, rise, fall;
  logic              busy_q, byte_q, start_q, new_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] hold_q, sh_q;
  logic              at_last, free, gen;

  assign rise    = ~sclk_q & sclk_i;
  assign fall    = sclk_q & ~sclk_i;
  assign at_last = cnt_q == (byte_q ? LAST_B : LAST_W);
  assign free    = ~busy_q | at_last;
  assign gen     = fs_gen_i & ~start_q & new_q & free;
  assign dat_o   = busy_q & sh_q[DATA_W-1];
  assign rise_o  = rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      busy_q  <= 1'b0;
      byte_q  <= 1'b0;
      start_q <= 1'b0;
      new_q   <= 1'b0;
      cnt_q   <= '0;
      hold_q  <= '0;
      sh_q    <= '0;
      fs_o    <= 1'b0;
      int_o   <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      int_o  <= 1'b0;
      if (fall && !fs_gen_i && fs_i && free) start_q <= 1'b1;
      if (rise) begin
        fs_o    <= gen;
        start_q <= gen;
        if (start_q) begin
          sh_q   <= byte_mode_i ? {wdata_hold_byte(hold_q)} : hold_q;
          byte_q <= byte_mode_i;
          busy_q <= 1'b1;
          cnt_q  <= '0;
          int_o  <= 1'b1;
        end else if (busy_q) begin
          if (at_last) begin
            busy_q <= 1'b0;
          end else begin
            sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
      // a write in the load cycle keeps the new data pending
      if (wr_i) begin
        hold_q <= wdata_i;
        new_q  <= 1'b1;
      end else if (rise && start_q) begin
        new_q <= 1'b0;
      end
    end
  end

  function automatic logic [DATA_W-1:0] wdata_hold_byte(input logic [DATA_W-1:0] v);
    return {v[BYTE_W-1:0], {(DATA_W-BYTE_W){1'b0}}};
  endfunction
endmodule

// File: rtl/serial_port_duplex.sv
module serial_port_duplex
  import serial_port_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_int_o,
  output logic              tx_int_o,
  input  logic              tx_sclk_i,
  input  logic              tx_fs_i,
  output logic              tx_fs_o,
  output logic              tx_fs_oe_o,
  output logic              tx_dat_o,
  input  logic              rx_sclk_i,
  input  logic              rx_fs_i,
  input  logic              rx_dat_i
);
  localparam int unsigned NSYNC = 5;

  sp_cfg_t          cfg_q;
  logic [NSYNC-1:0] raw, syn;
  logic             tx_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (reg_we_i && reg_sel_i) begin
      cfg_q.byte_mode <= reg_wdata_i[CFG_BYTE_BIT];
      cfg_q.fs_gen    <= reg_wdata_i[CFG_FSGEN_BIT];
    end
  end

  assign raw = {rx_dat_i, rx_fs_i, rx_sclk_i, tx_fs_i, tx_sclk_i};

  sp_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  sp_tx #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (syn[0]),
    .fs_i       (syn[1]),
    .fs_gen_i   (cfg_q.fs_gen),
    .byte_mode_i(cfg_q.byte_mode),
    .wr_i       (reg_we_i & ~reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .dat_o      (tx_dat_o),
    .fs_o       (tx_fs_o),
    .int_o      (tx_int_o),
    .rise_o     (tx_rise)
  );

  sp_rx #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (syn[2]),
    .fs_i       (syn[3]),
    .dat_i      (syn[4]),
    .byte_mode_i(cfg_q.byte_mode),
    .data_o     (rx_data_o),
    .int_o      (rx_int_o)
  );

  assign tx_fs_oe_o = cfg_q.fs_gen;
endmodule

// File: rtl/serial_port_duplex_chk.sv
module serial_port_duplex_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_int_o,
  input logic              tx_int_o,
  input logic              tx_dat_o,
  input logic              tx_fs_o,
  input logic              tx_fs_oe_o,
  input logic              tx_rise
);
  assert_rx_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_int_o |=> !rx_int_o);
  assert_rx_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_int_o |-> $stable(rx_data_o));
  assert_tx_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_dat_o) |-> $past(tx_rise));
  assert_tx_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_int_o |=> !tx_int_o);
  assert_tx_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_int_o |-> $past(tx_rise));
  assert_fs_dir_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fs_o |-> tx_fs_oe_o);
  assert_fs_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_fs_o) |-> $past(tx_rise));
endmodule

bind serial_port_duplex serial_port_duplex_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rx_data_o (rx_data_o),
  .rx_int_o  (rx_int_o),
  .tx_int_o  (tx_int_o),
  .tx_dat_o  (tx_dat_o),
  .tx_fs_o   (tx_fs_o),
  .tx_fs_oe_o(tx_fs_oe_o),
  .tx_rise   (tx_rise)
);

// File: tb/test_serial_port_duplex.sv
module test_serial_port_duplex;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] rx_data;
  logic rx_int, tx_int, tx_fs_o, tx_fs_oe, tx_dat;
  logic tx_sclk = 1'b0, tx_fs = 1'b0, rx_sclk = 1'b0, rx_fs = 1'b0, rx_dat = 1'b0;

  int checks = 0, fails = 0;
  int rx_pulses = 0, rx_hi = 0, tx_pulses = 0, tx_hi = 0;
  logic rx_int_d = 1'b0, tx_int_d = 1'b0;

  always #10 clk = ~clk;

  serial_port_duplex i_serial_port_duplex (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .rx_data_o(rx_data), .rx_int_o(rx_int),
    .tx_int_o(tx_int), .tx_sclk_i(tx_sclk), .tx_fs_i(tx_fs), .tx_fs_o(tx_fs_o),
    .tx_fs_oe_o(tx_fs_oe), .tx_dat_o(tx_dat), .rx_sclk_i(rx_sclk),
    .rx_fs_i(rx_fs), .rx_dat_i(rx_dat)
  );

  always @(posedge clk) begin
    rx_int_d <= rx_int;
    tx_int_d <= tx_int;
    if (rx_int) rx_hi++;
    if (tx_int) tx_hi++;
    if (rx_int && !rx_int_d) rx_pulses++;
    if (tx_int && !tx_int_d) tx_pulses++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic tick(input logic rfs, input logic rbit, input logic tfs,
                      output logic tbit, output logic tfso);
    @(negedge clk);
    tx_sclk = 1'b1; rx_sclk = 1'b1;
    rx_fs = rfs; rx_dat = rbit; tx_fs = tfs;
    repeat (HALF) @(negedge clk);
    tbit = tx_dat; tfso = tx_fs_o;
    tx_sclk = 1'b0; rx_sclk = 1'b0;
    repeat (HALF - 1) @(negedge clk);
  endtask

  // frame with frame sync input on both sides
  task automatic frame(input logic [15:0] rword, input int len, output logic [15:0] tword);
    logic b, f;
    tword = '0;
    tick(1'b1, 1'b0, 1'b1, b, f);
    for (int i = len - 1; i >= 0; i--) begin
      tick(1'b0, rword[i], 1'b0, b, f);
      tword = {tword[14:0], b};
    end
    tick(1'b0, 1'b0, 1'b0, b, f);
    check("R4 idle data", int'(b), 0);
    tick(1'b0, 1'b0, 1'b0, b, f);
  endtask

  task automatic t_reset;
    check("R1 rx_data", int'(rx_data), 0);
    check("R1 rx_int", int'(rx_int), 0);
    check("R1 tx_int", int'(tx_int), 0);
    check("R1 tx_dat", int'(tx_dat), 0);
    check("R1 tx_fs_o", int'(tx_fs_o), 0);
    check("R1 tx_fs_oe", int'(tx_fs_oe), 0);
  endtask

  task automatic t_duplex_word;  // R2 R4 R6 R9 R10
    logic [15:0] tw;
    int rp = rx_pulses, tp = tx_pulses, rh = rx_hi, th = tx_hi;
    reg_write(1'b0, 16'hA5C3);
    frame(16'h3C5A, 16, tw);
    check("R4 R9 tx word", int'(tw), 16'hA5C3);
    check("R2 R9 rx word", int'(rx_data), 16'h3C5A);
    check("R2 rx pulses", rx_pulses - rp, 1);
    check("R2 rx width", rx_hi - rh, 1);
    check("R6 tx pulses", tx_pulses - tp, 1);
    check("R6 tx width", tx_hi - th, 1);
  endtask

  task automatic t_retransmit;  // R7
    logic [15:0] tw;
    int tp = tx_pulses;
    frame(16'hFFFF, 16, tw);
    check("R7 resent word", int'(tw), 16'hA5C3);
    check("R7 tx pulse", tx_pulses - tp, 1);
    check("R2 all ones", int'(rx_data), 16'hFFFF);
  endtask

  task automatic t_byte;  // R3 R5 R10
    logic [15:0] tw;
    reg_write(1'b1, 16'h0001);
    reg_write(1'b0, 16'h12B7);
    frame(16'h0096, 8, tw);
    check("R5 tx byte", int'(tw), 16'h00B7);
    check("R3 rx byte", int'(rx_data), 16'h0096);
    frame(16'h00E1, 8, tw);
    check("R3 rx byte upper zero", int'(rx_data), 16'h00E1);
  endtask

  task automatic t_fs_gen;  // R8
    logic b, f;
    logic [15:0] tw = '0;
    int tp;
    reg_write(1'b1, 16'h0002);
    check("R8 fs_oe", int'(tx_fs_oe), 1);
    reg_write(1'b0, 16'h8001);
    tp = tx_pulses;
    tick(1'b0, 1'b0, 1'b0, b, f);
    check("R8 fs pulse", int'(f), 1);
    check("R8 no data with fs", int'(b), 0);
    for (int i = 0; i < 16; i++) begin
      tick(1'b0, 1'b0, 1'b0, b, f);
      tw = {tw[14:0], b};
      if (i == 0) check("R8 fs one period", int'(f), 0);
    end
    check("R8 generated word", int'(tw), 16'h8001);
    for (int i = 0; i < 4; i++) begin
      tick(1'b0, 1'b0, 1'b0, b, f);
      if (f) check("R8 spurious fs", 1, 0);
    end
    check("R8 single load", tx_pulses - tp, 1);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_duplex_word();
    t_retransmit();
    t_byte();
    t_fs_gen();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule